// File: doc/BRIEF.md
# Bit and Word Alignment Controller for a 7:1 Video Receiver

This controller sits in the divided receive clock domain of a 7:1 source-synchronous video receiver. It works out where to sample the serial lanes and where each 7-bit word starts. It watches the deserialized copy of the forwarded clock. It steps the receive PLL's dynamic phase forward through all sixteen positions. At each position it waits for the PLL to settle, then compares several consecutive clock words. If any of those words differ, the position lies on or near a transition and is marked unstable.

After the sweep it finds the longest circular run of stable positions and checks that the run is wide enough. It then steps the PLL forward to the middle of that run and raises the bit lock flag.

Word alignment follows. The controller pulses the deserializer's word-rotate input, which moves the word boundary by two bits per pulse, until the clock word reads `1100011`. It then raises word lock and ready. A window that is too narrow, or seven rotations that never match, clears the flags and starts a new sweep without outside help. An update request, accepted only while the PLL reports lock, starts a fresh run at any time.

Top module: `vid_rx_align`

## Requirements
- R1: While reset is high, every output is 0.
- R2: A run starts only when the update input is high while the PLL lock input is high. An update pulse while lock is low produces no phase step and no status change.
- R3: The phase direction output is always 0 (forward). Each phase step is a one-cycle pulse that moves the PLL one position of 16, and two step pulses are never in adjacent cycles.
- R4: A sweep samples all 16 positions and issues exactly 15 steps between them. After each step the controller waits the settle time, then compares 4 consecutive clock words. Any difference marks the position unstable. The total step count of a run is therefore 15 plus the forward distance from the last swept position to the chosen centre.
- R5: The chosen window is the longest circular run of stable positions, counted across position 15 back to 0, in absolute positions counted from reset. Among equal runs, the one whose first position has the lowest index wins. The centre is first + floor((length-1)/2), modulo 16. The PLL reaches the centre by forward steps only, and the window-size output reports the run length (1 to 16).
- R6: Bit lock rises only after the PLL sits at the centre, and only for a run of 3 or more positions. No phase step occurs while bit lock is high.
- R7: After bit lock, each word-rotate pulse lasts one cycle, is never adjacent to another, and moves the word by two bit positions. The controller issues the smallest number of pulses (0 to 6) that makes the clock word equal 7'h63. Word lock and ready then rise together.
- R8: If the best run is shorter than 3, or the word still differs from 7'h63 after 7 pulses, the controller clears bit lock, word lock and ready and starts a new sweep by itself.
- R9: An accepted update during or after a run clears bit lock, word lock, ready and the window size in the next cycle and starts a new sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Divided receive clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pll_lock_i | input | 1 | PLL lock indication; enables start |
| update_i | input | 1 | Start or restart request |
| clk_word_i | input | 7 | Deserialized forwarded-clock word |
| phase_step_o | output | 1 | One-cycle PLL phase advance pulse |
| phase_dir_o | output | 1 | PLL phase direction, held at 0 |
| word_align_o | output | 1 | One-cycle word-rotate pulse to the deserializer |
| win_size_o | output | 5 | Length of the selected stable window |
| bit_lock_o | output | 1 | Phase parked at the window centre |
| word_lock_o | output | 1 | Clock word matches 7'h63 |
| ready_o | output | 1 | Alignment complete |

## Verification
The hardest conditions to reach from the ports are a window that wraps across position 15, and two windows of equal length where the lower start index must win. Both depend on which PLL positions look unstable. The bench's PLL and deserializer model makes a chosen set of positions unstable by inverting the clock word on alternate cycles there. This lets each run set up a wrapping window, a tie of two three-position windows, a full-stable sweep, a two-position failure and a word that can never match. The failure cases are confirmed by watching the steps resume after the flags clear.

// File: rtl/align_pkg.sv
package align_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_EVAL   = 3'd3,
        ST_MOVE   = 3'd4,
        ST_WCHECK = 3'd5,
        ST_DONE   = 3'd6
    } align_st_e;

endpackage

// File: rtl/align_word_checker.sv
// Captures a reference word on start, then compares NCMP-1 further words.
// done_o pulses once; stable_o is valid from that cycle on.
module align_word_checker #(
    parameter int WORD_W = 7,
    parameter int NCMP   = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              done_o,
    output logic              stable_o
);
    localparam int CNT_W = $clog2(NCMP + 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] ref_w;
        logic              bad;
        logic              done;
        logic              stable;
    } chk_t;

    chk_t chk_q, chk_d;
    logic mis;

    always_comb begin
        chk_d      = chk_q;
        chk_d.done = 1'b0;
        mis        = chk_q.bad | (word_i != chk_q.ref_w);
        if (start_i) begin
            chk_d.active = 1'b1;
            chk_d.cnt    = '0;
            chk_d.ref_w  = word_i;
            chk_d.bad    = 1'b0;
            chk_d.stable = 1'b0;
        end else if (chk_q.active) begin
            chk_d.bad = mis;
            if (chk_q.cnt == CNT_W'(NCMP - 2)) begin
                chk_d.active = 1'b0;
                chk_d.done   = 1'b1;
                chk_d.stable = ~mis;
            end else begin
                chk_d.cnt = chk_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) chk_q <= '0;
        else       chk_q <= chk_d;
    end

    assign done_o   = chk_q.done;
    assign stable_o = chk_q.stable;

endmodule

// File: rtl/align_window_finder.sv
// Longest circular run of stable phases; lowest start index wins a tie.
module align_window_finder #(
    parameter int NPHASE = 16,
    parameter int PH_W   = $clog2(NPHASE),
    parameter int WIN_W  = $clog2(NPHASE + 1)
) (
    input  logic [NPHASE-1:0] mask_i,
    output logic [WIN_W-1:0]  len_o,
    output logic [PH_W-1:0]   ctr_o
);
    logic [NPHASE-1:0][WIN_W-1:0] run_len;

    for (genvar s = 0; s < NPHASE; s++) begin : g_run
        logic [WIN_W-1:0] len_s;
        always_comb begin : p_run
            logic            go;
            logic [PH_W-1:0] idx;
            len_s = '0;
            go    = 1'b1;
            for (int k = 0; k < NPHASE; k++) begin
                idx = PH_W'((s + k) % NPHASE);
                if (go && mask_i[idx]) len_s = len_s + WIN_W'(1);
                else                   go    = 1'b0;
            end
        end
        assign run_len[s] = len_s;
    end

    always_comb begin
        len_o = '0;
        ctr_o = '0;
        for (int s = 0; s < NPHASE; s++) begin
            if (run_len[s] > len_o) begin
                len_o = run_len[s];
                ctr_o = PH_W'((s + (int'(run_len[s]) - 1) / 2) % NPHASE);
            end
        end
    end

endmodule

// File: rtl/vid_rx_align.sv
module vid_rx_align
    import align_pkg::*;
#(
    parameter int                NPHASE      = 16,
    parameter int                WORD_W      = 7,
    parameter int                SETTLE_CYC  = 8,
    parameter int                NCMP        = 4,
    parameter int                MIN_WIN     = 3,
    parameter int                MAX_ROT     = 7,
    parameter logic [WORD_W-1:0] CLK_PATTERN = 7'h63
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             pll_lock_i,
    input  logic                             update_i,
    input  logic [WORD_W-1:0]                clk_word_i,
    output logic                             phase_step_o,
    output logic                             phase_dir_o,
    output logic                             word_align_o,
    output logic [$clog2(NPHASE+1)-1:0]      win_size_o,
    output logic                             bit_lock_o,
    output logic                             word_lock_o,
    output logic                             ready_o
);
    localparam int PH_W  = $clog2(NPHASE);
    localparam int WIN_W = $clog2(NPHASE + 1);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam int ROT_W = $clog2(MAX_ROT + 1);
    localparam logic [SET_W-1:0] SETTLE_LOAD = SET_W'(SETTLE_CYC);

    typedef struct packed {
        align_st_e         st;
        align_st_e         ret;
        logic [SET_W-1:0]  settle;
        logic [PH_W-1:0]   phase;
        logic [WIN_W-1:0]  visited;
        logic [NPHASE-1:0] mask;
        logic [PH_W-1:0]   target;
        logic [ROT_W-1:0]  rots;
        logic [WIN_W-1:0]  win;
        logic              step;
        logic              align;
        logic              chk_start;
        logic              bit_lock;
        logic              word_lock;
        logic              ready;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             chk_done, chk_stable;
    logic [WIN_W-1:0] best_len;
    logic [PH_W-1:0]  best_ctr;

    function automatic logic [PH_W-1:0] ph_next(input logic [PH_W-1:0] p);
        return (p == PH_W'(NPHASE - 1)) ? '0 : p + PH_W'(1);
    endfunction

    // Issue one forward phase step, then settle and resume in ret_st
    function automatic ctl_t pulse_step(input ctl_t c, input align_st_e ret_st);
        c.step   = 1'b1;
        c.phase  = ph_next(c.phase);
        c.settle = SETTLE_LOAD;
        c.ret    = ret_st;
        c.st     = ST_SETTLE;
        return c;
    endfunction

    // Drop all status and begin a fresh sweep at the current phase
    function automatic ctl_t sweep_from(input ctl_t c);
        c.st        = ST_SETTLE;
        c.ret       = ST_SAMPLE;
        c.settle    = SETTLE_LOAD;
        c.visited   = '0;
        c.mask      = '0;
        c.win       = '0;
        c.rots      = '0;
        c.bit_lock  = 1'b0;
        c.word_lock = 1'b0;
        c.ready     = 1'b0;
        c.step      = 1'b0;
        c.align     = 1'b0;
        c.chk_start = 1'b0;
        return c;
    endfunction

    align_word_checker #(
        .WORD_W (WORD_W),
        .NCMP   (NCMP)
    ) u_chk (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (ctl_q.chk_start),
        .word_i   (clk_word_i),
        .done_o   (chk_done),
        .stable_o (chk_stable)
    );

    align_window_finder #(
        .NPHASE (NPHASE),
        .PH_W   (PH_W),
        .WIN_W  (WIN_W)
    ) u_win (
        .mask_i (ctl_q.mask),
        .len_o  (best_len),
        .ctr_o  (best_ctr)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.step      = 1'b0;
        ctl_d.align     = 1'b0;
        ctl_d.chk_start = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
            end
            ST_SETTLE: begin
                if (ctl_q.settle == '0) begin
                    ctl_d.st        = ctl_q.ret;
                    ctl_d.chk_start = (ctl_q.ret == ST_SAMPLE);
                end else begin
                    ctl_d.settle = ctl_q.settle - SET_W'(1);
                end
            end
            ST_SAMPLE: begin
                if (chk_done) begin
                    ctl_d.mask[ctl_q.phase] = chk_stable;
                    if (ctl_q.visited == WIN_W'(NPHASE - 1)) begin
                        ctl_d.st = ST_EVAL;
                    end else begin
                        ctl_d         = pulse_step(ctl_d, ST_SAMPLE);
                        ctl_d.visited = ctl_q.visited + WIN_W'(1);
                    end
                end
            end
            ST_EVAL: begin
                if (best_len >= WIN_W'(MIN_WIN)) begin
                    ctl_d.win    = best_len;
                    ctl_d.target = best_ctr;
                    ctl_d.st     = ST_MOVE;
                end else begin
                    ctl_d = sweep_from(ctl_q);
                end
            end
            ST_MOVE: begin
                if (ctl_q.phase == ctl_q.target) begin
                    ctl_d.bit_lock = 1'b1;
                    ctl_d.rots     = '0;
                    ctl_d.st       = ST_WCHECK;
                end else begin
                    ctl_d = pulse_step(ctl_d, ST_MOVE);
                end
            end
            ST_WCHECK: begin
                if (clk_word_i == CLK_PATTERN) begin
                    ctl_d.word_lock = 1'b1;
                    ctl_d.ready     = 1'b1;
                    ctl_d.st        = ST_DONE;
                end else if (ctl_q.rots == ROT_W'(MAX_ROT)) begin
                    ctl_d = sweep_from(ctl_q);
                end else begin
                    ctl_d.align  = 1'b1;
                    ctl_d.rots   = ctl_q.rots + ROT_W'(1);
                    ctl_d.settle = SETTLE_LOAD;
                    ctl_d.ret    = ST_WCHECK;
                    ctl_d.st     = ST_SETTLE;
                end
            end
            ST_DONE: begin
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (update_i && pll_lock_i) ctl_d = sweep_from(ctl_q);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctl_q <= '0;
        else       ctl_q <= ctl_d;
    end

    assign phase_step_o = ctl_q.step;
    assign phase_dir_o  = 1'b0;
    assign word_align_o = ctl_q.align;
    assign win_size_o   = ctl_q.win;
    assign bit_lock_o   = ctl_q.bit_lock;
    assign word_lock_o  = ctl_q.word_lock;
    assign ready_o      = ctl_q.ready;

endmodule

// File: rtl/align_props.sv
module align_props #(
    parameter int WIN_W   = 5,
    parameter int MIN_WIN = 3
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             phase_step_o,
    input logic             word_align_o,
    input logic [WIN_W-1:0] win_size_o,
    input logic             bit_lock_o,
    input logic             word_lock_o,
    input logic             ready_o
);
    a_r3_step_gap: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_step_o |=> !phase_step_o);

    a_r7_align_gap: assert property (@(posedge clk_i) disable iff (rst_i)
        word_align_o |=> !word_align_o);

    a_r3_no_dual_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        !(phase_step_o && word_align_o));

    a_r6_no_step_locked: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_lock_o |-> !phase_step_o);

    a_r6_min_window: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_lock_o |-> (win_size_o >= WIN_W'(MIN_WIN)));

    a_r7_align_phase: assert property (@(posedge clk_i) disable iff (rst_i)
        word_align_o |-> (bit_lock_o && !word_lock_o));

    a_r7_ready_locks: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> (bit_lock_o && word_lock_o));

    a_r7_word_after_bit: assert property (@(posedge clk_i) disable iff (rst_i)
        word_lock_o |-> bit_lock_o);
endmodule

bind vid_rx_align align_props #(
    .WIN_W   ($clog2(NPHASE + 1)),
    .MIN_WIN (MIN_WIN)
) u_align_props (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .phase_step_o (phase_step_o),
    .word_align_o (word_align_o),
    .win_size_o   (win_size_o),
    .bit_lock_o   (bit_lock_o),
    .word_lock_o  (word_lock_o),
    .ready_o      (ready_o)
);

// File: tb/vid_rx_align_bench.sv
`timescale 1ns/1ps
module vid_rx_align_bench;
    logic       clk = 1'b0, rst = 1'b1, pll_lock = 1'b0, update = 1'b0;
    logic [6:0] clk_word = 7'h63;
    logic       phase_step, phase_dir, word_align, bit_lock, word_lock, ready;
    logic [4:0] win_size;

    always #2 clk = ~clk;

    vid_rx_align u_vid_rx_align (
        .clk_i(clk), .rst_i(rst), .pll_lock_i(pll_lock), .update_i(update),
        .clk_word_i(clk_word), .phase_step_o(phase_step), .phase_dir_o(phase_dir),
        .word_align_o(word_align), .win_size_o(win_size), .bit_lock_o(bit_lock),
        .word_lock_o(word_lock), .ready_o(ready)
    );

    typedef struct {int ctr; int len; int rots; int steps; string name;} exp_t;
    exp_t sb_q[$];

    int total = 0, bad = 0;
    int pll_ph = 0, rot = 0, step_cnt = 0, align_cnt = 0, gap_err = 0, dir_err = 0;
    bit tog = 0, prev_step = 0, prev_align = 0, prev_ready = 0, bl_seen = 0, wl_seen = 0;
    logic [15:0] good_mask = 16'hFFFF;
    logic [6:0]  base = 7'h63;

    function automatic logic [6:0] rot2(input logic [6:0] w, input int n);
        logic [6:0] x = w;
        for (int i = 0; i < (n % 7); i++) x = {x[4:0], x[6:5]};
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // PLL and deserializer model
    always @(negedge clk) begin
        logic [6:0] w;
        if (!rst) begin
            if (phase_step === 1'b1) begin pll_ph = (pll_ph + 1) % 16; step_cnt++; end
            if (word_align === 1'b1) begin rot = (rot + 1) % 7; align_cnt++; end
            if (phase_step === 1'b1 && prev_step) gap_err++;
            if (word_align === 1'b1 && prev_align) gap_err++;
            if (phase_dir !== 1'b0) dir_err++;
            if (bit_lock === 1'b1) bl_seen = 1;
            if (word_lock === 1'b1) wl_seen = 1;
            prev_step  = (phase_step === 1'b1);
            prev_align = (word_align === 1'b1);
        end
        tog = ~tog;
        w   = rot2(base, rot);
        clk_word = (!good_mask[pll_ph] && tog) ? ~w : w;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (!rst && ready === 1'b1 && !prev_ready) begin
            if (sb_q.size() == 0) begin
                check(0, "R7", "ready without pending run", 1, 0);
            end else begin
                e = sb_q.pop_front();
                check(pll_ph == e.ctr, "R5", {e.name, " centre phase"}, pll_ph, e.ctr);
                check(int'(win_size) == e.len, "R5", {e.name, " window size"}, win_size, e.len);
                check(align_cnt == e.rots, "R7", {e.name, " rotate pulses"}, align_cnt, e.rots);
                check(step_cnt == e.steps, "R4", {e.name, " step pulses"}, step_cnt, e.steps);
                check(bit_lock && word_lock, "R6", {e.name, " lock flags"}, {bit_lock, word_lock}, 3);
            end
        end
        prev_ready = (ready === 1'b1);
    end

    function automatic logic [6:0] base_for(input int k);
        return rot2(7'h63, (14 - ((rot + k) % 7)) % 7);
    endfunction

    task automatic pulse_update();
        @(negedge clk); update = 1'b1;
        @(negedge clk); update = 1'b0;
        step_cnt = 0; align_cnt = 0; bl_seen = 0; wl_seen = 0;
    endtask

    task automatic run_case(input string name, input logic [15:0] m, input logic [6:0] b);
        exp_t e;
        int   p0, l, c;
        good_mask = m; base = b;
        pulse_update();
        check(!bit_lock && !ready && win_size == 0, "R9", {name, " flags cleared"}, {bit_lock, ready}, 0);
        p0 = pll_ph;
        l = 0; c = 0;
        for (int s = 0; s < 16; s++) begin
            int  n = 0;
            bit  go = 1;
            for (int k = 0; k < 16; k++) begin
                if (go && m[(s + k) % 16]) n++; else go = 0;
            end
            if (n > l) begin l = n; c = (s + (n - 1) / 2) % 16; end
        end
        e.ctr = c; e.len = l; e.name = name;
        e.steps = 15 + ((c - p0 - 15 + 32) % 16);
        e.rots = -1;
        for (int k = 6; k >= 0; k--) if (rot2(b, rot + k) == 7'h63) e.rots = k;
        sb_q.push_back(e);
        for (int i = 0; i < 20000 && ready !== 1'b1; i++) @(negedge clk);
        @(negedge clk);
        check(ready === 1'b1, "R7", {name, " ready reached"}, ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WD", "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        // R1: reset state
        check({phase_step, phase_dir, word_align, win_size, bit_lock, word_lock, ready} == '0,
              "R1", "outputs in reset", {phase_step, word_align, win_size, bit_lock, ready}, 0);
        rst = 1'b0;
        // R2: update ignored while PLL not locked
        pulse_update();
        repeat (200) @(negedge clk);
        check(step_cnt == 0 && !bit_lock && !ready, "R2", "no activity without lock", step_cnt, 0);
        pll_lock = 1'b1;

        run_case("wrap", 16'hE7C7, base_for(3));
        run_case("tie", 16'hEE00, base_for(0));      // R9 rerun after ready
        run_case("full", 16'hFFFF, base_for(6));
        run_case("even", 16'h00F0, base_for(0));

        // R8: window of two never locks, sweeps repeat
        good_mask = 16'h00C0;
        pulse_update();
        for (int i = 0; i < 20000 && step_cnt < 40; i++) @(negedge clk);
        check(step_cnt >= 40, "R8", "resweep steps after narrow window", step_cnt, 40);
        check(!bl_seen, "R6", "no bit lock on 2-phase window", bl_seen, 0);

        // R8: word never matches, gives up after 7 rotations
        good_mask = 16'hE7C7; base = 7'h01;
        pulse_update();
        for (int i = 0; i < 20000 && !(align_cnt >= 7 && bl_seen && bit_lock === 1'b0); i++) @(negedge clk);
        check(align_cnt == 7, "R7", "rotate pulses before give-up", align_cnt, 7);
        check(!wl_seen && !bit_lock, "R8", "flags cleared after failed rotation", bit_lock, 0);
        snap = step_cnt;
        for (int i = 0; i < 400 && step_cnt == snap; i++) @(negedge clk);
        check(step_cnt > snap, "R8", "sweep resumes after word failure", step_cnt, snap + 1);

        run_case("recover", 16'hE7C7, base_for(2));

        check(gap_err == 0, "R3", "adjacent strobe pulses", gap_err, 0);
        check(dir_err == 0, "R3", "direction output non-zero", dir_err, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule